// File: doc/BRIEF.md
# Cache line maintenance controller

This block carries out line-level maintenance operations on a small direct-mapped cache pair: an instruction cache that holds only tags and valid bits, and a data cache that holds tags, valid bits, dirty bits and line data. A maintenance command arrives as a 32-bit instruction word together with a byte address. The controller decodes the word, maps the address onto a line, and then invalidates that line, clears it only on a tag match, or flushes it. A flush of a dirty line first streams every word of the line out through a memory write port with a valid/ready handshake.

The line length in words and the number of lines are parameters. The index and tag come from the address after a shift of two bits for the byte offset plus the base-2 logarithm of the line length. A parameter selects write-back mode. When it is off, flush and clear-on-match both fall back to a plain data-cache invalidate. A preload port writes line state and data words, and a probe port reads line state back. Both are used to set up and observe the cache around each command.

The controller is a five-state machine. IDLE accepts a legal command (IDLE to DECIDE). DECIDE reads the addressed line. From DECIDE it goes to WRITE for a flush of a valid dirty line, to DONE for a clear whose tag misses, and to INVAL in every other case. WRITE holds each word until it is accepted and moves to INVAL after the last accepted word. INVAL wipes the line and moves to DONE. DONE pulses `done` for one cycle and returns to IDLE.

Top module: `cache_maint_ctrl`

## Requirements
- R1: A command is accepted in IDLE when `cmd_valid` is high, instr[31:26] = 100100, instr[25:21] = 00000 and instr[10:0] is one of the four codes: 00001101000 (instruction invalidate), 00001100100 (data invalidate), 00001110100 (flush), 00001100110 (clear-on-match). Any other word leaves `busy` low in the next cycle and changes no line.
- R2: The line index is bits [OFF+IDX_W-1:OFF] of the address and the tag is the bits above them, where OFF = 2 + log2(LINE_WORDS). The index therefore wraps modulo NUM_LINES. With the defaults (8 words, 8 lines) the index is addr[7:5] and the tag is addr[31:8].
- R3: An instruction invalidate sets the instruction-cache line's valid bit and tag to zero and leaves the data cache unchanged.
- R4: A data invalidate sets the data line's valid bit, dirty bit and tag to zero and issues no memory write.
- R5: In write-back mode, a flush of a valid dirty line writes LINE_WORDS words, one per accepted handshake. The address of word w is {stored tag, index, w, 2'b00} and its data is word w of the line. The line is then invalidated as in R4.
- R6: A flush of a clean or invalid line issues no memory write and invalidates the line.
- R7: In write-back mode, a clear-on-match invalidates the data line only when it is valid and its stored tag equals the address tag. It never writes memory. On a miss, `done` comes 2 cycles after acceptance instead of 3.
- R8: With WRITEBACK = 0, flush and clear-on-match behave exactly as a data invalidate and `mem_wvalid` never rises.
- R9: `busy` is high from the cycle after acceptance until the end of the single-cycle `done` pulse. For commands with no write phase, `done` is high in the 3rd cycle after acceptance. Commands presented while busy are ignored.
- R10: While `mem_wvalid` is high and `mem_wready` is low, `mem_wvalid`, `mem_waddr` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid, dirty and tag state |
| cmd_valid | input | 1 | Command strobe |
| cmd_instr | input | 32 | Maintenance instruction word |
| cmd_addr | input | ADDR_W | Byte address of the target line |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_wvalid | output | 1 | Write-back word valid |
| mem_wready | input | 1 | Write-back word accepted |
| mem_waddr | output | ADDR_W | Write-back word address |
| mem_wdata | output | DATA_W | Write-back word data |
| ld_line_en | input | 1 | Preload line state |
| ld_icache | input | 1 | Preload targets the instruction cache |
| ld_idx | input | IDX_W | Preload line index |
| ld_tag | input | TAG_W | Preload tag |
| ld_valid | input | 1 | Preload valid bit |
| ld_dirty | input | 1 | Preload dirty bit (data cache only) |
| ld_word_en | input | 1 | Preload one data word |
| ld_word | input | WORD_W | Preload word position in the line |
| ld_wdata | input | DATA_W | Preload word value |
| pr_icache | input | 1 | Probe the instruction cache |
| pr_idx | input | IDX_W | Probe line index |
| pr_valid | output | 1 | Probed valid bit |
| pr_dirty | output | 1 | Probed dirty bit (0 for the instruction cache) |
| pr_tag | output | TAG_W | Probed tag |

## Verification
The assertions check the handshake and sequencing rules on every cycle. They cover the single-cycle `done` pulse inside `busy`, the start after a legal command and the idle state after any other, the holding of a stalled write word, and the 4-byte address step between accepted words. They also check that the write-through variant never raises `mem_wvalid`. The bench scenarios are needed for the decisions that depend on stored line contents. These are a flush that writes or skips depending on the dirty and valid bits, a clear that hits or misses on the tag, and an index that wraps from a high address. The scenarios also cover a command ignored during a stalled flush and the exact data of each written word, which the bench compares against its own model of the line arrays.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int INSTR_W = 32;

    localparam logic [5:0]  MAINT_OPCODE = 6'b100100;
    localparam logic [10:0] FN_ICACHE_INV = 11'b00001101000;
    localparam logic [10:0] FN_DCACHE_INV = 11'b00001100100;
    localparam logic [10:0] FN_FLUSH      = 11'b00001110100;
    localparam logic [10:0] FN_CLEAR      = 11'b00001100110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ICINV,
        OP_DCINV,
        OP_FLUSH,
        OP_CLEAR
    } maint_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_WRITE,
        ST_INVAL,
        ST_DONE
    } maint_state_e;

endpackage

// File: rtl/cmc_decode.sv
module cmc_decode
    import cmc_pkg::*;
#(
    parameter bit WRITEBACK = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output maint_op_e          op
);

    logic       hdr_ok;
    logic [10:0] fn;
    logic       unused_reg_fields;

    assign hdr_ok            = (instr[31:26] == MAINT_OPCODE) && (instr[25:21] == 5'd0);
    assign fn                = instr[10:0];
    assign unused_reg_fields = ^instr[20:11];

    always_comb begin
        op = OP_NONE;
        if (hdr_ok) begin
            if (fn == FN_ICACHE_INV) begin
                op = OP_ICINV;
            end else if (fn == FN_DCACHE_INV) begin
                op = OP_DCINV;
            end else if (fn == FN_FLUSH) begin
                op = WRITEBACK ? OP_FLUSH : OP_DCINV;
            end else if (fn == FN_CLEAR) begin
                op = WRITEBACK ? OP_CLEAR : OP_DCINV;
            end
        end
    end

endmodule

// File: rtl/cmc_addr_map.sv
module cmc_addr_map #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int NUM_LINES  = 8
) (
    input  logic [ADDR_W-1:0]                                          addr,
    output logic [$clog2(NUM_LINES)-1:0]                               idx,
    output logic [ADDR_W-$clog2(LINE_WORDS)-2-$clog2(NUM_LINES)-1:0]   tag
);

    localparam int OFF_W = $clog2(LINE_WORDS) + 2;
    localparam int IDX_W = $clog2(NUM_LINES);

    logic unused_offset_bits;

    assign idx                = addr[OFF_W +: IDX_W];
    assign tag                = addr[ADDR_W-1 : OFF_W+IDX_W];
    assign unused_offset_bits = ^addr[OFF_W-1:0];

endmodule

// File: rtl/cmc_iline_store.sv
module cmc_iline_store #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en,
    input  logic [$clog2(NUM_LINES)-1:0]  ld_idx,
    input  logic [TAG_W-1:0]              ld_tag,
    input  logic                          ld_valid,
    input  logic                          clr_en,
    input  logic [$clog2(NUM_LINES)-1:0]  clr_idx,
    input  logic [$clog2(NUM_LINES)-1:0]  pr_idx,
    output logic                          pr_valid,
    output logic [TAG_W-1:0]              pr_tag
);

    logic [TAG_W-1:0] tag_q   [NUM_LINES];
    logic             valid_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
            end else if (clr_en && (clr_idx == g)) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
            end else if (ld_en && (ld_idx == g)) begin
                tag_q[g]   <= ld_tag;
                valid_q[g] <= ld_valid;
            end
        end
    end

    assign pr_valid = valid_q[pr_idx];
    assign pr_tag   = tag_q[pr_idx];

endmodule

// File: rtl/cmc_dline_store.sv
module cmc_dline_store #(
    parameter int NUM_LINES  = 8,
    parameter int LINE_WORDS = 8,
    parameter int TAG_W      = 24,
    parameter int DATA_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_en,
    input  logic [$clog2(NUM_LINES)-1:0]   ld_idx,
    input  logic [TAG_W-1:0]               ld_tag,
    input  logic                           ld_valid,
    input  logic                           ld_dirty,
    input  logic                           dw_en,
    input  logic [$clog2(NUM_LINES)-1:0]   dw_idx,
    input  logic [$clog2(LINE_WORDS)-1:0]  dw_word,
    input  logic [DATA_W-1:0]              dw_data,
    input  logic                           clr_en,
    input  logic [$clog2(NUM_LINES)-1:0]   clr_idx,
    input  logic [$clog2(NUM_LINES)-1:0]   rd_idx,
    input  logic [$clog2(LINE_WORDS)-1:0]  rd_word,
    output logic                           rd_valid,
    output logic                           rd_dirty,
    output logic [TAG_W-1:0]               rd_tag,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [$clog2(NUM_LINES)-1:0]   pr_idx,
    output logic                           pr_valid,
    output logic                           pr_dirty,
    output logic [TAG_W-1:0]               pr_tag
);

    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int WORD_W  = $clog2(LINE_WORDS);
    localparam int N_WORDS = NUM_LINES * LINE_WORDS;

    logic [TAG_W-1:0]  tag_q   [NUM_LINES];
    logic              valid_q [NUM_LINES];
    logic              dirty_q [NUM_LINES];
    logic [DATA_W-1:0] data_q  [N_WORDS];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (clr_en && (clr_idx == g)) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (ld_en && (ld_idx == g)) begin
                tag_q[g]   <= ld_tag;
                valid_q[g] <= ld_valid;
                dirty_q[g] <= ld_dirty;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dw_en) begin
            data_q[{dw_idx, dw_word}] <= dw_data;
        end
    end

    logic [IDX_W+WORD_W-1:0] rd_flat;
    assign rd_flat = {rd_idx, rd_word};

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_flat];

    assign pr_valid = valid_q[pr_idx];
    assign pr_dirty = dirty_q[pr_idx];
    assign pr_tag   = tag_q[pr_idx];

endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmc_pkg::*;
#(
    parameter int  ADDR_W     = 32,
    parameter int  DATA_W     = 32,
    parameter int  LINE_WORDS = 8,
    parameter int  NUM_LINES  = 8,
    parameter bit  WRITEBACK  = 1'b1,
    localparam int WORD_W     = $clog2(LINE_WORDS),
    localparam int IDX_W      = $clog2(NUM_LINES),
    localparam int TAG_W      = ADDR_W - WORD_W - 2 - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [INSTR_W-1:0] cmd_instr,
    input  logic [ADDR_W-1:0]  cmd_addr,
    output logic               busy,
    output logic               done,
    output logic               mem_wvalid,
    input  logic               mem_wready,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               ld_line_en,
    input  logic               ld_icache,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [TAG_W-1:0]   ld_tag,
    input  logic               ld_valid,
    input  logic               ld_dirty,
    input  logic               ld_word_en,
    input  logic [WORD_W-1:0]  ld_word,
    input  logic [DATA_W-1:0]  ld_wdata,
    input  logic               pr_icache,
    input  logic [IDX_W-1:0]   pr_idx,
    output logic               pr_valid,
    output logic               pr_dirty,
    output logic [TAG_W-1:0]   pr_tag
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

    // ---------------- decode and address mapping ----------------
    maint_op_e        cmd_op;
    logic             cmd_legal;
    logic [IDX_W-1:0] cmd_idx;
    logic [TAG_W-1:0] cmd_tag;

    cmc_decode #(
        .WRITEBACK (WRITEBACK)
    ) u_decode (
        .instr (cmd_instr),
        .op    (cmd_op)
    );

    cmc_addr_map #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .NUM_LINES  (NUM_LINES)
    ) u_addr_map (
        .addr (cmd_addr),
        .idx  (cmd_idx),
        .tag  (cmd_tag)
    );

    assign cmd_legal = cmd_valid && (cmd_op != OP_NONE);

    // ---------------- state and command context ----------------
    maint_state_e     state_q, state_d;
    maint_op_e        op_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic [WORD_W-1:0] cnt_q;

    logic              d_rd_valid, d_rd_dirty;
    logic [TAG_W-1:0]  d_rd_tag;
    logic [DATA_W-1:0] d_rd_data;
    logic              line_hit;
    logic              d_clr, i_clr;

    assign line_hit = d_rd_valid && (d_rd_tag == tag_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_legal) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                unique case (op_q)
                    OP_FLUSH: state_d = (d_rd_valid && d_rd_dirty) ? ST_WRITE : ST_INVAL;
                    OP_CLEAR: state_d = line_hit ? ST_INVAL : ST_DONE;
                    default:  state_d = ST_INVAL;
                endcase
            end
            ST_WRITE: begin
                if (mem_wready && (cnt_q == LAST_WORD)) begin
                    state_d = ST_INVAL;
                end
            end
            ST_INVAL: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // command context and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_NONE;
            idx_q <= '0;
            tag_q <= '0;
            cnt_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && cmd_legal) begin
                op_q  <= cmd_op;
                idx_q <= cmd_idx;
                tag_q <= cmd_tag;
            end
            if (state_q == ST_DECIDE) begin
                cnt_q <= '0;
            end else if ((state_q == ST_WRITE) && mem_wready) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        done       = 1'b0;
        mem_wvalid = 1'b0;
        d_clr      = 1'b0;
        i_clr      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy       = 1'b0;
            ST_DECIDE: ;
            ST_WRITE:  mem_wvalid = 1'b1;
            ST_INVAL: begin
                i_clr = (op_q == OP_ICINV);
                d_clr = (op_q != OP_ICINV);
            end
            ST_DONE:   done       = 1'b1;
            default:   busy       = 1'b0;
        endcase
    end

    assign mem_waddr = {d_rd_tag, idx_q, cnt_q, 2'b00};
    assign mem_wdata = d_rd_data;

    // ---------------- line storage ----------------
    logic              i_pr_valid, d_pr_valid, d_pr_dirty;
    logic [TAG_W-1:0]  i_pr_tag, d_pr_tag;

    cmc_dline_store #(
        .NUM_LINES  (NUM_LINES),
        .LINE_WORDS (LINE_WORDS),
        .TAG_W      (TAG_W),
        .DATA_W     (DATA_W)
    ) u_dstore (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_line_en && !ld_icache),
        .ld_idx   (ld_idx),
        .ld_tag   (ld_tag),
        .ld_valid (ld_valid),
        .ld_dirty (ld_dirty),
        .dw_en    (ld_word_en),
        .dw_idx   (ld_idx),
        .dw_word  (ld_word),
        .dw_data  (ld_wdata),
        .clr_en   (d_clr),
        .clr_idx  (idx_q),
        .rd_idx   (idx_q),
        .rd_word  (cnt_q),
        .rd_valid (d_rd_valid),
        .rd_dirty (d_rd_dirty),
        .rd_tag   (d_rd_tag),
        .rd_data  (d_rd_data),
        .pr_idx   (pr_idx),
        .pr_valid (d_pr_valid),
        .pr_dirty (d_pr_dirty),
        .pr_tag   (d_pr_tag)
    );

    cmc_iline_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_istore (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_line_en && ld_icache),
        .ld_idx   (ld_idx),
        .ld_tag   (ld_tag),
        .ld_valid (ld_valid),
        .clr_en   (i_clr),
        .clr_idx  (idx_q),
        .pr_idx   (pr_idx),
        .pr_valid (i_pr_valid),
        .pr_tag   (i_pr_tag)
    );

    assign pr_valid = pr_icache ? i_pr_valid : d_pr_valid;
    assign pr_dirty = pr_icache ? 1'b0       : d_pr_dirty;
    assign pr_tag   = pr_icache ? i_pr_tag   : d_pr_tag;

endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter bit WRITEBACK = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_legal,
    input logic              busy,
    input logic              done,
    input logic              mem_wvalid,
    input logic              mem_wready,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [DATA_W-1:0] mem_wdata
);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_ends_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_start_on_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_legal) |=> busy);

    p_stay_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_legal)) |=> !busy);

    p_hold_stalled_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=>
            (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && mem_wready) |=>
            (!mem_wvalid || (mem_waddr == $past(mem_waddr) + ADDR_W'(4))));

    p_write_inside_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (busy && !done));

    if (!WRITEBACK) begin : g_no_wb
        p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_wvalid);
    end

endmodule

bind cache_maint_ctrl cmc_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WRITEBACK (WRITEBACK)
) u_cmc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_legal  (cmd_legal),
    .busy       (busy),
    .done       (done),
    .mem_wvalid (mem_wvalid),
    .mem_wready (mem_wready),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int NL = 8;
    localparam int WW = 3;
    localparam int IW = 3;
    localparam int TW = AW - WW - 2 - IW;
    localparam int WATCHDOG = 150000;

    localparam logic [10:0] F_IC = 11'b00001101000;
    localparam logic [10:0] F_DC = 11'b00001100100;
    localparam logic [10:0] F_FL = 11'b00001110100;
    localparam logic [10:0] F_CL = 11'b00001100110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid_wb = 1'b0, cmd_valid_wt = 1'b0;
    logic [31:0] cmd_instr = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic mem_wready = 1'b0;
    logic ld_line_en = 1'b0, ld_icache = 1'b0, ld_valid = 1'b0, ld_dirty = 1'b0, ld_word_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [TW-1:0] ld_tag = '0;
    logic [WW-1:0] ld_word = '0;
    logic [DW-1:0] ld_wdata = '0;
    logic pr_icache = 1'b0;
    logic [IW-1:0] pr_idx = '0;

    logic busy_wb, done_wb, wv_wb, prv_wb, prd_wb;
    logic [AW-1:0] wa_wb;
    logic [DW-1:0] wd_wb;
    logic [TW-1:0] prt_wb;
    logic busy_wt, done_wt, wv_wt, prv_wt, prd_wt;
    logic [AW-1:0] wa_wt;
    logic [DW-1:0] wd_wt;
    logic [TW-1:0] prt_wt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_maint_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .NUM_LINES(NL), .WRITEBACK(1'b1))
    i_cache_maint_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_wb), .cmd_instr(cmd_instr), .cmd_addr(cmd_addr),
        .busy(busy_wb), .done(done_wb), .mem_wvalid(wv_wb), .mem_wready(mem_wready),
        .mem_waddr(wa_wb), .mem_wdata(wd_wb),
        .ld_line_en(ld_line_en), .ld_icache(ld_icache), .ld_idx(ld_idx), .ld_tag(ld_tag),
        .ld_valid(ld_valid), .ld_dirty(ld_dirty), .ld_word_en(ld_word_en), .ld_word(ld_word),
        .ld_wdata(ld_wdata), .pr_icache(pr_icache), .pr_idx(pr_idx),
        .pr_valid(prv_wb), .pr_dirty(prd_wb), .pr_tag(prt_wb));

    cache_maint_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .NUM_LINES(NL), .WRITEBACK(1'b0))
    i_cache_maint_ctrl_wt (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_wt), .cmd_instr(cmd_instr), .cmd_addr(cmd_addr),
        .busy(busy_wt), .done(done_wt), .mem_wvalid(wv_wt), .mem_wready(mem_wready),
        .mem_waddr(wa_wt), .mem_wdata(wd_wt),
        .ld_line_en(ld_line_en), .ld_icache(ld_icache), .ld_idx(ld_idx), .ld_tag(ld_tag),
        .ld_valid(ld_valid), .ld_dirty(ld_dirty), .ld_word_en(ld_word_en), .ld_word(ld_word),
        .ld_wdata(ld_wdata), .pr_icache(pr_icache), .pr_idx(pr_idx),
        .pr_valid(prv_wt), .pr_dirty(prd_wt), .pr_tag(prt_wt));

    // ---------------- reference model ----------------
    bit             mdv [2][NL];
    bit             mdd [2][NL];
    logic [TW-1:0]  mdt [2][NL];
    bit             miv [2][NL];
    logic [TW-1:0]  mit [2][NL];
    logic [DW-1:0]  mdat [NL][LW];
    logic [AW+DW-1:0] exp_q [$];

    int  n_checks = 0;
    int  n_fail = 0;
    int  cycles = 0;
    bit  hold_low = 1'b0;
    int  stall_ctr = 0;
    bit  wt_wrote = 1'b0;
    bit  prev_stall = 1'b0;
    logic [AW-1:0] prev_a = '0;
    logic [DW-1:0] prev_d = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] tag_of(input int i);
        return TW'(24'h3C1000 + i);
    endfunction

    function automatic logic [AW-1:0] mk_addr(input logic [TW-1:0] t, input int i, input logic [4:0] off);
        return {t, i[IW-1:0], off};
    endfunction

    function automatic logic [31:0] mk_instr(input logic [10:0] f);
        return {6'b100100, 5'd0, 5'd3, 5'd4, f};
    endfunction

    // applies the command to the model, returns expected latency (-1: write phase)
    function automatic int model_apply(input int s, input logic [10:0] f, input logic [AW-1:0] a);
        int i;
        logic [TW-1:0] t;
        int lat;
        i = int'(a[7:5]);
        t = a[31:8];
        lat = 3;
        if (f == F_IC) begin
            miv[s][i] = 0; mit[s][i] = '0;
        end else begin
            bit wipe;
            wipe = 1'b1;
            if (f == F_FL && s == 0 && mdv[s][i] && mdd[s][i]) begin
                for (int w = 0; w < LW; w++)
                    exp_q.push_back({mdt[s][i], i[IW-1:0], w[WW-1:0], 2'b00, mdat[i][w]});
                lat = -1;
            end
            if (f == F_CL && s == 0 && !(mdv[s][i] && mdt[s][i] == t)) begin
                wipe = 1'b0;
                lat = 2;
            end
            if (wipe) begin
                mdv[s][i] = 0; mdd[s][i] = 0; mdt[s][i] = '0;
            end
        end
        return lat;
    endfunction

    // ---------------- per-clock monitor ----------------
    always @(posedge clk) begin
        cycles++;
        #1;
        stall_ctr++;
        mem_wready = hold_low ? 1'b0 : ((stall_ctr % 3) != 1);
        if (cycles > WATCHDOG) begin
            chk(1'b0, "R9", "watchdog expired", 64'(cycles), 64'(WATCHDOG));
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wv_wt) wt_wrote = 1'b1;
            if (prev_stall)
                chk(wv_wb && wa_wb == prev_a && wd_wb == prev_d, "R10", "stalled word held",
                    {wa_wb, wd_wb}, {prev_a, prev_d});
            if (wv_wb && mem_wready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", {wa_wb, wd_wb}, 64'd0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    chk({wa_wb, wd_wb} == e, "R5", "write word addr/data", {wa_wb, wd_wb}, e);
                end
            end
            prev_stall = wv_wb && !mem_wready;
            prev_a = wa_wb;
            prev_d = wd_wb;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(input int s, input logic [31:0] ins, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_instr = ins;
        cmd_addr = a;
        if (s == 0) cmd_valid_wb = 1'b1; else cmd_valid_wt = 1'b1;
        @(negedge clk);
        cmd_valid_wb = 1'b0;
        cmd_valid_wt = 1'b0;
    endtask

    task automatic wait_done(input int s, input int exp_lat, input string req);
        int cnt;
        cnt = 1;
        while (!(s == 0 ? done_wb : done_wt)) begin
            @(negedge clk);
            cnt++;
        end
        if (exp_lat > 0)
            chk(cnt == exp_lat, req, "cycles from acceptance to done", 64'(cnt), 64'(exp_lat));
        @(negedge clk);
        chk(!(s == 0 ? (done_wb || busy_wb) : (done_wt || busy_wt)), "R9",
            "done single pulse then idle", 64'(s == 0 ? {done_wb, busy_wb} : {done_wt, busy_wt}), 64'd0);
    endtask

    task automatic compare_all(input int s, input string req);
        for (int i = 0; i < NL; i++) begin
            logic [TW+1:0] act, exp;
            pr_idx = i[IW-1:0];
            pr_icache = 1'b0;
            #1;
            act = (s == 0) ? {prv_wb, prd_wb, prt_wb} : {prv_wt, prd_wt, prt_wt};
            exp = {mdv[s][i], mdd[s][i], mdt[s][i]};
            chk(act == exp, req, $sformatf("data line %0d state", i), 64'(act), 64'(exp));
            pr_icache = 1'b1;
            #1;
            act = (s == 0) ? {prv_wb, prd_wb, prt_wb} : {prv_wt, prd_wt, prt_wt};
            exp = {miv[s][i], 1'b0, mit[s][i]};
            chk(act == exp, req, $sformatf("instr line %0d state", i), 64'(act), 64'(exp));
        end
    endtask

    task automatic do_cmd(input int s, input logic [10:0] f, input logic [AW-1:0] a, input string req);
        int lat;
        lat = model_apply(s, f, a);
        issue(s, mk_instr(f), a);
        wait_done(s, lat, req);
        compare_all(s, req);
        chk(exp_q.size() == 0, req, "all expected words written", 64'(exp_q.size()), 64'd0);
    endtask

    task automatic preload();
        for (int i = 0; i < NL; i++) begin
            @(negedge clk);
            ld_line_en = 1'b1; ld_icache = 1'b0; ld_idx = i[IW-1:0];
            ld_tag = tag_of(i); ld_valid = 1'b1; ld_dirty = (i % 2 == 0);
            @(negedge clk);
            ld_icache = 1'b1; ld_tag = tag_of(i) ^ TW'(24'h000F00); ld_dirty = 1'b0;
            for (int s = 0; s < 2; s++) begin
                mdv[s][i] = 1; mdd[s][i] = (i % 2 == 0); mdt[s][i] = tag_of(i);
                miv[s][i] = 1; mit[s][i] = tag_of(i) ^ TW'(24'h000F00);
            end
            @(negedge clk);
            ld_line_en = 1'b0; ld_icache = 1'b0;
            for (int w = 0; w < LW; w++) begin
                ld_word_en = 1'b1; ld_word = w[WW-1:0];
                ld_wdata = 32'hA000_0000 | (i << 8) | w;
                mdat[i][w] = 32'hA000_0000 | (i << 8) | w;
                @(negedge clk);
            end
            ld_word_en = 1'b0;
        end
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_wb && !done_wb && !wv_wb, "R9", "reset outputs idle",
            64'({busy_wb, done_wb, wv_wb}), 64'd0);
        compare_all(0, "R3");

        preload();
        compare_all(0, "R2");
        compare_all(1, "R2");

        // instruction invalidate, line 2, offset inside the line
        do_cmd(0, F_IC, mk_addr(tag_of(2) ^ TW'(24'h000F00), 2, 5'h14), "R3");
        // data invalidate of a dirty line: no write, line wiped
        do_cmd(0, F_DC, mk_addr(tag_of(4), 4, 5'h00), "R4");
        // flush of a dirty line with handshake stalls
        do_cmd(0, F_FL, mk_addr(tag_of(6), 6, 5'h08), "R5");
        // flush of a clean line, then of an already invalid line
        do_cmd(0, F_FL, mk_addr(tag_of(1), 1, 5'h00), "R6");
        do_cmd(0, F_FL, mk_addr(tag_of(4), 4, 5'h00), "R6");
        // clear with wrong tag keeps the dirty line, with right tag wipes it
        do_cmd(0, F_CL, mk_addr(tag_of(0) + 1'b1, 0, 5'h00), "R7");
        do_cmd(0, F_CL, mk_addr(tag_of(0), 0, 5'h04), "R7");
        // index wraps: address 0x1E0 has line offset 15, i.e. line 7 with tag 1
        do_cmd(0, F_DC, 32'h0000_01E0, "R2");

        // command while busy is ignored (flush of dirty line 2 held by stalls)
        begin
            int lat;
            hold_low = 1'b1;
            lat = model_apply(0, F_FL, mk_addr(tag_of(2), 2, 5'h00));
            issue(0, mk_instr(F_FL), mk_addr(tag_of(2), 2, 5'h00));
            issue(0, mk_instr(F_DC), mk_addr(tag_of(3), 3, 5'h00));
            chk(busy_wb, "R9", "busy during stalled flush", 64'(busy_wb), 64'd1);
            repeat (3) @(negedge clk);
            hold_low = 1'b0;
            wait_done(0, lat, "R9");
            compare_all(0, "R9");
            chk(exp_q.size() == 0, "R5", "flush words drained", 64'(exp_q.size()), 64'd0);
        end

        // write-through variant: flush and clear degrade to invalidate
        do_cmd(1, F_FL, mk_addr(tag_of(2), 2, 5'h00), "R8");
        do_cmd(1, F_CL, mk_addr(tag_of(0) + 1'b1, 0, 5'h00), "R8");
        chk(!wt_wrote, "R8", "write-through variant never wrote", 64'(wt_wrote), 64'd0);

        // illegal words: wrong function code, wrong opcode
        issue(0, mk_instr(11'b00001100101), mk_addr(tag_of(3), 3, 5'h00));
        chk(!busy_wb, "R1", "unknown function not accepted", 64'(busy_wb), 64'd0);
        issue(0, {6'b100101, 5'd0, 5'd3, 5'd4, F_DC}, mk_addr(tag_of(3), 3, 5'h00));
        chk(!busy_wb, "R1", "wrong opcode not accepted", 64'(busy_wb), 64'd0);
        issue(0, {6'b100100, 5'd1, 5'd3, 5'd4, F_DC}, mk_addr(tag_of(3), 3, 5'h00));
        chk(!busy_wb, "R1", "nonzero bits 25:21 not accepted", 64'(busy_wb), 64'd0);
        compare_all(0, "R1");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule